// File: doc/BRIEF.md
# Triple-Lane Majority-Voted Seven-Stage Pipeline

This block carries a data stream through seven pipeline stages built three times over. The three lanes compute the same thing. After every stage a bitwise two-out-of-three vote combines the three lane results. The voted word, not each lane's own word, is what all three lanes load into their next stage. A lane that goes wrong at one stage is therefore outvoted right there and cannot pass a bad value further down. A second fault, in another lane at another stage, is masked the same way.

Data enters and leaves through valid/ready handshakes. A beat is taken when `in_valid` and `in_ready` are both high. The pipeline advances as a whole whenever its last stage is empty or the consumer asserts `out_ready`, and `in_ready` equals that advance condition. While `out_valid` is high and `out_ready` is low, nothing moves: the output word holds and no input is taken. Each stage applies a fixed placeholder function to the voted word of the stage before it.

Each stage has a disagreement flag and a two-bit code naming the lane that lost the vote, for diagnosis. A set of fault-injection slots can XOR a mask into one lane's result at one stage just before the vote. These slots let a test corrupt lanes on purpose.

Top module: `tmr_pipe_top`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after, `out_valid` is 0, every `stg_mismatch` bit is 0 and every `stg_odd_lane` code is 0.
- R2: With no fault, a beat taken with word x leaves as g6(g5(...g0(x))), where gs(y) = (y rotated left by one bit) + (3·s + 1), modulo 2^WIDTH. Beats leave in their arrival order, seven advancing cycles after they are accepted.
- R3: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and no beat is taken.
- R4: Corrupting any single lane at any stage, for one cycle or for many, leaves the `out_data` and `out_valid` sequence equal to the fault-free one.
- R5: Simultaneous corruption of two different lanes at two different stages leaves the output sequence equal to the fault-free one.
- R6: `stg_mismatch[s]` is high in a cycle exactly when stage s holds a valid beat and some lane's injected-into result differs from the vote. `stg_odd_lane[2s+1:2s]` then gives the lowest such lane number plus one (1, 2 or 3), and is 0 otherwise.
- R7: Injection slot k is active when `flt_en[k]` is 1. It XORs `flt_mask[k·WIDTH +: WIDTH]` into lane `flt_lane[2k+1:2k]` of stage `flt_stage[3k+2:3k]`. A lane code of 3, a stage code of 7 or a zero mask has no effect on any output.
- R8: A fault lasts only while it is injected. In the first cycle with no active slot, no flag is raised, and all later output equals the fault-free output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Pipeline can take a beat this cycle |
| in_data | input | WIDTH | Input word |
| out_valid | output | 1 | Voted output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | WIDTH | Voted output word of the last stage |
| stg_mismatch | output | STAGES | Per-stage lane disagreement flag |
| stg_odd_lane | output | 2·STAGES | Per-stage code of the outvoted lane (0 none, 1 to 3 lane+1) |
| flt_en | input | NINJ | Injection slot enables |
| flt_stage | input | 3·NINJ | Target stage of each slot |
| flt_lane | input | 2·NINJ | Target lane of each slot |
| flt_mask | input | WIDTH·NINJ | XOR mask of each slot |

## Verification
A voter that stops feeding its result back into every lane keeps a corrupted lane wrong. The error then shows in `out_data` as soon as a second fault reaches the same beat in another lane. A lost vote shows within the remaining stage count of cycles, at most seven. A wrong stage function or a misordered stage corrupts every beat, and the first beat shows it after exactly seven advancing cycles. Flag and lane-code faults show in the same cycle as the injection, because the disagreement logic is combinational on the stage registers and the injection inputs. A stall-handling fault shows on the first cycle with `out_ready` low and a beat waiting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned LANES = 3;
  localparam int unsigned LANE_CODE_W = 2;

  typedef enum logic [1:0] {
    ODD_NONE = 2'd0,
    ODD_L0   = 2'd1,
    ODD_L1   = 2'd2,
    ODD_L2   = 2'd3
  } odd_lane_e;
endpackage

// File: rtl/tmr_lane_stage.sv
module tmr_lane_stage #(
  parameter int unsigned WIDTH     = 26,
  parameter int unsigned STAGE_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             d_valid,
  input  logic [WIDTH-1:0] d_word,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_word
);
  localparam logic [WIDTH-1:0] ADD_K = WIDTH'(3 * STAGE_IDX + 1);

  logic [WIDTH-1:0] rot_word;
  logic [WIDTH-1:0] fn_word;

  // placeholder stage function: rotate left by one, then add a stage constant
  assign rot_word = {d_word[WIDTH-2:0], d_word[WIDTH-1]};
  assign fn_word  = rot_word + ADD_K;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_word  <= '0;
    end else if (adv) begin
      q_valid <= d_valid;
      q_word  <= fn_word;
    end
  end
endmodule

// File: rtl/tmr_fault_inject.sv
module tmr_fault_inject #(
  parameter int unsigned WIDTH     = 26,
  parameter int unsigned NINJ      = 2,
  parameter int unsigned STAGE_IDX = 0,
  parameter int unsigned LANE_IDX  = 0
) (
  input  logic [NINJ-1:0]       flt_en,
  input  logic [3*NINJ-1:0]     flt_stage,
  input  logic [2*NINJ-1:0]     flt_lane,
  input  logic [WIDTH*NINJ-1:0] flt_mask,
  output logic [WIDTH-1:0]      mask_out
);
  localparam logic [2:0] MY_STAGE = 3'(STAGE_IDX);
  localparam logic [1:0] MY_LANE  = 2'(LANE_IDX);

  logic [WIDTH-1:0] slot_mask [NINJ];

  for (genvar k = 0; k < NINJ; k++) begin : g_slot
    logic hit;
    assign hit = flt_en[k]
               && (flt_stage[3*k +: 3] == MY_STAGE)
               && (flt_lane[2*k +: 2] == MY_LANE);
    assign slot_mask[k] = hit ? flt_mask[WIDTH*k +: WIDTH] : '0;
  end

  always_comb begin
    mask_out = '0;
    for (int k = 0; k < NINJ; k++) mask_out = mask_out | slot_mask[k];
  end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned WIDTH = 26
) (
  input  logic             va,
  input  logic             vb,
  input  logic             vc,
  input  logic [WIDTH-1:0] da,
  input  logic [WIDTH-1:0] db,
  input  logic [WIDTH-1:0] dc,
  output logic             v_vote,
  output logic [WIDTH-1:0] d_vote,
  output logic             disagree,
  output tmr_pkg::odd_lane_e odd
);
  import tmr_pkg::*;

  logic diff_a, diff_b, diff_c;

  assign d_vote = (da & db) | (db & dc) | (da & dc);
  assign v_vote = (va & vb) | (vb & vc) | (va & vc);

  assign diff_a = (da != d_vote);
  assign diff_b = (db != d_vote);
  assign diff_c = (dc != d_vote);

  always_comb begin
    if (diff_a)      odd = ODD_L0;
    else if (diff_b) odd = ODD_L1;
    else if (diff_c) odd = ODD_L2;
    else             odd = ODD_NONE;
  end

  assign disagree = diff_a | diff_b | diff_c;
endmodule

// File: rtl/tmr_pipe_top.sv
module tmr_pipe_top #(
  parameter int unsigned WIDTH  = 26,
  parameter int unsigned STAGES = 7,
  parameter int unsigned NINJ   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WIDTH-1:0]        in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WIDTH-1:0]        out_data,
  output logic [STAGES-1:0]       stg_mismatch,
  output logic [2*STAGES-1:0]     stg_odd_lane,
  input  logic [NINJ-1:0]         flt_en,
  input  logic [3*NINJ-1:0]       flt_stage,
  input  logic [2*NINJ-1:0]       flt_lane,
  input  logic [WIDTH*NINJ-1:0]   flt_mask
);
  import tmr_pkg::*;

  localparam int unsigned LAST = STAGES - 1;

  logic             lane_v   [STAGES][LANES];
  logic [WIDTH-1:0] lane_q   [STAGES][LANES];
  logic [WIDTH-1:0] lane_o   [STAGES][LANES];
  logic [WIDTH-1:0] inj_mask [STAGES][LANES];
  logic             vote_v   [STAGES];
  logic [WIDTH-1:0] vote_d   [STAGES];
  logic             disagree [STAGES];
  odd_lane_e        odd      [STAGES];
  logic             adv;

  // whole-pipe advance: last stage empty or consumer taking it
  assign adv      = !vote_v[LAST] || out_ready;
  assign in_ready = adv;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic             src_v;
    logic [WIDTH-1:0] src_d;

    if (s == 0) begin : g_head
      assign src_v = in_valid;
      assign src_d = in_data;
    end else begin : g_body
      assign src_v = vote_v[s-1];
      assign src_d = vote_d[s-1];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      tmr_lane_stage #(
        .WIDTH    (WIDTH),
        .STAGE_IDX(s)
      ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .d_valid(src_v),
        .d_word (src_d),
        .q_valid(lane_v[s][l]),
        .q_word (lane_q[s][l])
      );

      tmr_fault_inject #(
        .WIDTH    (WIDTH),
        .NINJ     (NINJ),
        .STAGE_IDX(s),
        .LANE_IDX (l)
      ) u_inj (
        .flt_en   (flt_en),
        .flt_stage(flt_stage),
        .flt_lane (flt_lane),
        .flt_mask (flt_mask),
        .mask_out (inj_mask[s][l])
      );

      assign lane_o[s][l] = lane_q[s][l] ^ inj_mask[s][l];
    end

    tmr_voter #(
      .WIDTH(WIDTH)
    ) u_vote (
      .va      (lane_v[s][0]),
      .vb      (lane_v[s][1]),
      .vc      (lane_v[s][2]),
      .da      (lane_o[s][0]),
      .db      (lane_o[s][1]),
      .dc      (lane_o[s][2]),
      .v_vote  (vote_v[s]),
      .d_vote  (vote_d[s]),
      .disagree(disagree[s]),
      .odd     (odd[s])
    );

    assign stg_mismatch[s]       = vote_v[s] && disagree[s];
    assign stg_odd_lane[2*s +: 2] = stg_mismatch[s] ? odd[s] : ODD_NONE;
  end

  assign out_valid = vote_v[LAST];
  assign out_data  = vote_d[LAST];
endmodule

// File: rtl/tmr_pipe_chk.sv
module tmr_pipe_chk #(
  parameter int unsigned WIDTH  = 26,
  parameter int unsigned STAGES = 7,
  parameter int unsigned NINJ   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [WIDTH-1:0]    out_data,
  input logic [STAGES-1:0]   stg_mismatch,
  input logic [2*STAGES-1:0] stg_odd_lane,
  input logic [NINJ-1:0]     flt_en
);
  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ready_when_empty_R3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_no_flag_without_fault_R6: assert property (@(posedge clk) disable iff (rst)
    (flt_en == '0) |-> (stg_mismatch == '0));

  for (genvar s = 0; s < STAGES; s++) begin : g_flag
    assert_flag_names_lane_R6: assert property (@(posedge clk) disable iff (rst)
      stg_mismatch[s] |-> (stg_odd_lane[2*s +: 2] != 2'd0));
    assert_code_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !stg_mismatch[s] |-> (stg_odd_lane[2*s +: 2] == 2'd0));
  end
endmodule

bind tmr_pipe_top tmr_pipe_chk #(
  .WIDTH (WIDTH),
  .STAGES(STAGES),
  .NINJ  (NINJ)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .stg_mismatch(stg_mismatch),
  .stg_odd_lane(stg_odd_lane),
  .flt_en      (flt_en)
);

// File: tb/test_tmr_pipe_top.sv
`timescale 1ns/1ps
module test_tmr_pipe_top;
  localparam int W  = 26;
  localparam int NS = 7;
  localparam int NI = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_data;
  logic [NS-1:0] stg_mismatch;
  logic [2*NS-1:0] stg_odd_lane;
  logic [NI-1:0] flt_en = '0;
  logic [3*NI-1:0] flt_stage = '0;
  logic [2*NI-1:0] flt_lane = '0;
  logic [W*NI-1:0] flt_mask = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference state: one valid flag and word per stage
  bit           mv [NS];
  logic [W-1:0] md [NS];

  always #4 clk = ~clk;

  tmr_pipe_top #(.WIDTH(W), .STAGES(NS), .NINJ(NI)) i_tmr_pipe_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .stg_mismatch(stg_mismatch), .stg_odd_lane(stg_odd_lane),
    .flt_en(flt_en), .flt_stage(flt_stage), .flt_lane(flt_lane), .flt_mask(flt_mask)
  );

  function automatic logic [W-1:0] gfun(int s, logic [W-1:0] y);
    logic [W-1:0] r;
    r = (y << 1) | (y >> (W - 1));
    return r + W'(3 * s + 1);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference update at each edge
  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin mv[s] = 0; md[s] = '0; end
    end else if (!mv[NS-1] || out_ready) begin
      for (int s = NS - 1; s > 0; s--) begin
        mv[s] = mv[s-1];
        md[s] = gfun(s, md[s-1]);
      end
      mv[0] = in_valid;
      md[0] = gfun(0, in_data);
    end
  end

  // compare on every cycle, mid-period
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_rdy;
      exp_rdy = !mv[NS-1] || out_ready;
      check(in_ready == exp_rdy, "R3 in_ready", 64'(in_ready), 64'(exp_rdy));
      check(out_valid == mv[NS-1], "R2/R4/R5 out_valid", 64'(out_valid), 64'(mv[NS-1]));
      if (mv[NS-1])
        check(out_data == md[NS-1], "R2/R4/R5/R8 out_data", 64'(out_data), 64'(md[NS-1]));
      for (int s = 0; s < NS; s++) begin
        bit f; logic [1:0] c;
        f = 0; c = 2'd0;
        for (int k = 0; k < NI; k++) begin
          if (flt_en[k] && flt_stage[3*k +: 3] == 3'(s) && flt_lane[2*k +: 2] != 2'd3
              && flt_mask[W*k +: W] != '0 && mv[s]) begin
            f = 1; c = flt_lane[2*k +: 2] + 2'd1;
          end
        end
        check(stg_mismatch[s] == f, "R6/R7/R8 stg_mismatch", 64'(stg_mismatch[s]), 64'(f));
        check(stg_odd_lane[2*s +: 2] == c, "R6 stg_odd_lane", 64'(stg_odd_lane[2*s +: 2]), 64'(c));
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic set_slot(int k, bit en, int st, int ln, logic [W-1:0] m);
    flt_en[k] = en;
    flt_stage[3*k +: 3] = 3'(st);
    flt_lane[2*k +: 2] = 2'(ln);
    flt_mask[W*k +: W] = m;
  endtask

  task automatic clear_slots();
    flt_en = '0; flt_stage = '0; flt_lane = '0; flt_mask = '0;
  endtask

  task automatic drive_beat(bit v);
    in_valid = v;
    in_data = W'(rnd());
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) step();
    // R1: reset state seen while reset is held
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(stg_mismatch == '0, "R1 stg_mismatch", 64'(stg_mismatch), 64'd0);
    check(stg_odd_lane == '0, "R1 stg_odd_lane", 64'(stg_odd_lane), 64'd0);
    rst = 0;
    step();
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);

    // R2: steady stream, no stall
    for (int i = 0; i < 24; i++) begin drive_beat(1); out_ready = 1; step(); end
    // R3: irregular source and sink
    for (int i = 0; i < 60; i++) begin
      drive_beat(rnd() % 3 != 0);
      out_ready = (rnd() % 4) > 1;
      step();
    end
    out_ready = 1;
    // R4: one lane at each stage, one cycle at a time
    for (int s = 0; s < NS; s++) begin
      for (int l = 0; l < 3; l++) begin
        drive_beat(1);
        set_slot(0, 1, s, l, W'(rnd()) | W'(1));
        step();
        clear_slots();
        drive_beat(1);
        step();   // R8: first clean cycle after the fault
      end
    end
    // R5: two lanes at two stages at once, under back-pressure
    for (int i = 0; i < 20; i++) begin
      drive_beat(rnd() % 4 != 0);
      out_ready = (rnd() % 3) != 0;
      set_slot(0, 1, 2, 0, W'(rnd()) | W'(4));
      set_slot(1, 1, 5, 2, W'(rnd()) | W'(2));
      step();
    end
    clear_slots();
    out_ready = 1;
    // R4: persistent fault in the last stage
    for (int i = 0; i < 15; i++) begin
      drive_beat(1);
      set_slot(0, 1, NS - 1, 1, W'(rnd()) | W'(8));
      step();
    end
    clear_slots();
    // R7: lane code 3, stage code 7 and zero mask have no effect
    for (int i = 0; i < 6; i++) begin
      drive_beat(1);
      set_slot(0, 1, 3, 3, W'(rnd()) | W'(1));
      set_slot(1, 1, 7, 0, W'(rnd()) | W'(1));
      step();
      set_slot(0, 1, 4, 1, '0);
      set_slot(1, 0, 1, 2, W'(rnd()) | W'(1));
      step();
    end
    clear_slots();
    // R7: drain, then inject into an empty stage
    for (int i = 0; i < 10; i++) begin drive_beat(0); step(); end
    for (int l = 0; l < 3; l++) begin
      set_slot(0, 1, 3, l, W'(rnd()) | W'(1));
      step();
    end
    clear_slots();
    for (int i = 0; i < 12; i++) begin drive_beat(1); step(); end
    drive_beat(0);
    repeat (10) step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule